// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns two digital conditions into a clean system reset. One is a supply-good level from an external comparator. The other is an active-low manual request, typically a push button to ground. The block drives a pair of complementary reset outputs: one active low and one active high. Every reset event ends with a minimum-width pulse. The width of that pulse is a count of clock cycles set by a parameter. The default gives 200 ms at 125 MHz, and a testbench can shrink it.

Both asynchronous inputs pass through synchronizer chains. The manual input is also debounced: a new level is accepted only after the synchronized input has held it for a parameterized number of cycles. An accepted high-to-low change on the manual input starts a pulse. While the supply is flagged bad, reset is held. When the supply comes back, a full pulse is timed from the recovery. A trigger that arrives during a pulse restarts the full count, so reset always releases one full pulse width after the latest event.

The asynchronous power-on input `porN` puts every register into its initial state. In that state reset is asserted, and a full pulse is timed after `porN` is released.

Top module: `supv_reset`

## Requirements
- R1: While the synchronized supply-good level is low, reset is asserted. A supply drop is seen on `resetN` after the third rising clock edge that samples `supplyOk` low. Reset then stays asserted for as long as `supplyOk` stays low.
- R2: After `supplyOk` returns high, reset stays asserted and releases after exactly PULSE_CYCLES+3 rising edges, counted from the first edge that samples it high. A supply dip of a single cycle produces a reset that lasts PULSE_CYCLES+1 cycles.
- R3: An accepted high-to-low change of `manualN` asserts reset on the (DEBOUNCE_CYCLES+2)-th rising edge after the input falls. Reset then stays asserted for exactly PULSE_CYCLES cycles.
- R4: `resetHi` is at all times the inverse of `resetN`. Reset asserted means `resetN`=0 and `resetHi`=1.
- R5: A steady-high `manualN` never requests reset, and a low-to-high change of `manualN` never starts a pulse.
- R6: A low level on `manualN` that lasts fewer than DEBOUNCE_CYCLES clock cycles is ignored, and `resetN` stays high.
- R7: Holding `manualN` low after it has been accepted does not lengthen the pulse beyond PULSE_CYCLES.
- R8: A new accepted manual trigger during a pulse restarts the full count. Reset then releases PULSE_CYCLES cycles after the new trigger is accepted.
- R9: While `porN` is low, reset is asserted. After `porN` rises with `supplyOk` high, reset releases after PULSE_CYCLES+3 rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock that times the pulse and the debounce |
| porN | input | 1 | Asynchronous power-on initialization, active low |
| manualN | input | 1 | Manual reset request, active low, idles high |
| supplyOk | input | 1 | Supply-good level from an external comparator, high when the supply is good |
| resetN | output | 1 | Reset output, active low |
| resetHi | output | 1 | Reset output, active high, inverse of `resetN` |

## Verification
The bench sweeps manual low pulses from one cycle up to beyond the debounce length. A debounce that is off by one would either accept a pulse one cycle too short or reject one that is just long enough. A design that reacts to the level instead of the edge would stretch reset while the button is held. A design that triggers on the rising edge would produce a second pulse when the button is released. The bench retriggers during a pulse, which catches a counter that is not reloaded, and it sends a one-cycle supply dip, which catches a release timed from the dip rather than from the recovery.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_PULSE = 2'd1,
    ST_RUN   = 2'd2
  } supv_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPulse;
    logic stepPulse;
    logic takeLevel;
  } supv_strobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic supplyGood;
    logic manLevel;
    logic manSettled;
    logic pulseLast;
  } supv_status_t;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic porN,
  input  logic din,
  output logic dout
);

  logic chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) chain[i] <= RESET_VAL;
        else       chain[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) chain[i] <= RESET_VAL;
        else       chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int PULSE_CYCLES    = 25_000_000,
  parameter int DEBOUNCE_CYCLES = 2_500_000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic         clk,
  input  logic         porN,
  input  logic         manualN,
  input  logic         supplyOk,
  input  supv_strobe_t strobe,
  output supv_status_t status
);

  localparam int PULSE_W = $clog2(PULSE_CYCLES + 1);
  localparam int DEB_W   = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [PULSE_W-1:0] PULSE_FULL = PULSE_W'(PULSE_CYCLES);
  localparam logic [DEB_W-1:0]   DEB_LAST   = DEB_W'(DEBOUNCE_CYCLES - 1);

  logic manSync;
  logic supSync;

  // button idles high, supply assumed bad until proven good
  supv_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_syncMan (
    .clk  (clk),
    .porN (porN),
    .din  (manualN),
    .dout (manSync)
  );

  supv_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_syncSup (
    .clk  (clk),
    .porN (porN),
    .din  (supplyOk),
    .dout (supSync)
  );

  // debounce: count cycles the synchronized input disagrees with the held level
  logic [DEB_W-1:0] debCnt;
  logic             debLevel;
  logic             debDiffers;

  assign debDiffers = (manSync != debLevel);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      debCnt   <= '0;
      debLevel <= 1'b1;
    end else if (strobe.takeLevel) begin
      debCnt   <= '0;
      debLevel <= manSync;
    end else if (!debDiffers) begin
      debCnt   <= '0;
    end else begin
      debCnt   <= debCnt + DEB_W'(1);
    end
  end

  // pulse-width down counter
  logic [PULSE_W-1:0] pulseCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pulseCnt <= PULSE_FULL;
    end else if (strobe.loadPulse) begin
      pulseCnt <= PULSE_FULL;
    end else if (strobe.stepPulse && (pulseCnt != '0)) begin
      pulseCnt <= pulseCnt - PULSE_W'(1);
    end
  end

  always_comb begin
    status.supplyGood = supSync;
    status.manLevel   = debLevel;
    status.manSettled = debDiffers && (debCnt == DEB_LAST);
    status.pulseLast  = (pulseCnt <= PULSE_W'(1));
  end

endmodule

// File: rtl/supv_control.sv
module supv_control
  import supv_pkg::*;
(
  input  logic         clk,
  input  logic         porN,
  input  supv_status_t status,
  output supv_strobe_t strobe,
  output logic         rstLowQ,
  output logic         rstHighQ
);

  supv_state_e state;
  supv_state_e nextState;
  logic        manTrig;

  // accepted change while the held level is high is a falling edge
  assign manTrig = status.manSettled && status.manLevel;

  always_comb begin
    nextState        = state;
    strobe.loadPulse = 1'b0;
    strobe.stepPulse = 1'b0;
    strobe.takeLevel = status.manSettled;
    if (!status.supplyGood) begin
      nextState        = ST_HOLD;
      strobe.loadPulse = 1'b1;
    end else begin
      unique case (state)
        ST_HOLD: begin
          nextState        = ST_PULSE;
          strobe.loadPulse = 1'b1;
        end
        ST_PULSE: begin
          if (manTrig) begin
            strobe.loadPulse = 1'b1;
          end else if (status.pulseLast) begin
            nextState = ST_RUN;
          end else begin
            strobe.stepPulse = 1'b1;
          end
        end
        ST_RUN: begin
          if (manTrig) begin
            nextState        = ST_PULSE;
            strobe.loadPulse = 1'b1;
          end
        end
        default: begin
          nextState        = ST_HOLD;
          strobe.loadPulse = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state    <= ST_HOLD;
      rstLowQ  <= 1'b0;
      rstHighQ <= 1'b1;
    end else begin
      state    <= nextState;
      rstLowQ  <= (nextState == ST_RUN);
      rstHighQ <= (nextState != ST_RUN);
    end
  end

endmodule

// File: rtl/supv_reset.sv
module supv_reset
  import supv_pkg::*;
#(
  parameter int PULSE_CYCLES    = 25_000_000,
  parameter int DEBOUNCE_CYCLES = 2_500_000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic porN,
  input  logic manualN,
  input  logic supplyOk,
  output logic resetN,
  output logic resetHi
);

  supv_strobe_t strobe;
  supv_status_t status;

  supv_datapath #(
    .PULSE_CYCLES    (PULSE_CYCLES),
    .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES),
    .SYNC_STAGES     (SYNC_STAGES)
  ) u_datapath (
    .clk      (clk),
    .porN     (porN),
    .manualN  (manualN),
    .supplyOk (supplyOk),
    .strobe   (strobe),
    .status   (status)
  );

  supv_control u_control (
    .clk      (clk),
    .porN     (porN),
    .status   (status),
    .strobe   (strobe),
    .rstLowQ  (resetN),
    .rstHighQ (resetHi)
  );

endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
  parameter int PULSE_CYCLES = 25_000_000
) (
  input logic clk,
  input logic porN,
  input logic supplyOk,
  input logic resetN,
  input logic resetHi
);

  localparam int CW = $clog2(PULSE_CYCLES + 2) + 1;

  logic [CW-1:0] lowCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                          lowCnt <= '0;
    else if (resetN)                    lowCnt <= '0;
    else if (lowCnt != {CW{1'b1}})      lowCnt <= lowCnt + CW'(1);
  end

  a_r4_complement: assert property (@(posedge clk) disable iff (!porN)
    resetHi == !resetN);

  a_r1_supply_hold: assert property (@(posedge clk) disable iff (!porN)
    ($past(!supplyOk) && $past(!supplyOk, 2) && $past(!supplyOk, 3)) |-> !resetN);

  a_r2_release_needs_supply: assert property (@(posedge clk) disable iff (!porN)
    $rose(resetN) |-> $past(supplyOk, 3));

  a_r3_min_width: assert property (@(posedge clk) disable iff (!porN)
    $rose(resetN) |-> (lowCnt >= CW'(PULSE_CYCLES)));

endmodule

bind supv_reset supv_reset_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk      (clk),
  .porN     (porN),
  .supplyOk (supplyOk),
  .resetN   (resetN),
  .resetHi  (resetHi)
);

// File: tb/supv_reset_bench.sv
module supv_reset_bench;

  localparam int P = 20;
  localparam int D = 4;

  logic clk = 1'b0;
  logic porN, manualN, supplyOk;
  logic resetN, resetHi;

  int errors = 0;
  int checks = 0;
  int compMismatch = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  supv_reset #(.PULSE_CYCLES(P), .DEBOUNCE_CYCLES(D), .SYNC_STAGES(2)) u_supv_reset (
    .clk      (clk),
    .porN     (porN),
    .manualN  (manualN),
    .supplyOk (supplyOk),
    .resetN   (resetN),
    .resetHi  (resetHi)
  );

  // R4 monitor, sampled away from the active edge
  always @(negedge clk) if (resetHi !== ~resetN) compMismatch++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edgesUntil(input logic lvl, output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (resetN !== lvl && n < 500);
  endtask

  task automatic countLows(input int win, output int first, output int lows);
    first = 0; lows = 0;
    for (int i = 1; i <= win; i++) begin
      @(posedge clk); #1;
      if (resetN === 1'b0) begin
        lows++;
        if (first == 0) first = i;
      end
    end
  endtask

  task automatic manualTrial(input int len, output int first, output int lows);
    @(negedge clk);
    fork
      begin
        manualN = 1'b0;
        repeat (len) @(posedge clk);
        @(negedge clk);
        manualN = 1'b1;
      end
      countLows(len + 2 * D + P + 10, first, lows);
    join
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, first, lows;
    porN = 1'b0; manualN = 1'b1; supplyOk = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check(resetN === 1'b0, "R9 resetN during power-on", resetN, 0);
    check(resetHi === 1'b1, "R9 resetHi during power-on", resetHi, 1);

    @(negedge clk); porN = 1'b1;
    edgesUntil(1'b1, n);
    check(n == P + 3, "R9 release after power-on", n, P + 3);

    // R6 short lows ignored, R3 accepted lows give one pulse, R5 release no trigger
    for (int len = 1; len <= D + 2; len++) begin
      manualTrial(len, first, lows);
      if (len < D) begin
        check(lows == 0, "R6 short manual low ignored", lows, 0);
      end else begin
        check(first == D + 2, "R3 manual assert latency", first, D + 2);
        check(lows == P, "R3 R5 manual pulse width", lows, P);
      end
    end

    // R7 held low does not lengthen the pulse
    @(negedge clk); manualN = 1'b0;
    countLows(3 * P, first, lows);
    check(lows == P, "R7 held manual low", lows, P);
    @(negedge clk); manualN = 1'b1;
    countLows(2 * D + 6, first, lows);
    check(lows == 0, "R5 manual release no trigger", lows, 0);

    // R8 retrigger restarts full count
    @(negedge clk); manualN = 1'b0;
    edgesUntil(1'b0, n);
    check(n == D + 2, "R8 first trigger latency", n, D + 2);
    repeat (4) @(posedge clk);
    @(negedge clk); manualN = 1'b1;
    repeat (D + 3) @(posedge clk);
    @(negedge clk); manualN = 1'b0;
    edgesUntil(1'b1, n);
    check(n == D + 2 + P, "R8 retrigger release", n, D + 2 + P);
    @(negedge clk); manualN = 1'b1;
    repeat (D + 5) @(posedge clk);

    // R1 supply loss
    @(negedge clk); supplyOk = 1'b0;
    edgesUntil(1'b0, n);
    check(n == 3, "R1 supply loss latency", n, 3);
    countLows(50, first, lows);
    check(lows == 50, "R1 held while supply low", lows, 50);
    @(negedge clk); manualN = 1'b0;
    countLows(2 * D + 4, first, lows);
    check(lows == 2 * D + 4, "R1 manual during supply low", lows, 2 * D + 4);
    @(negedge clk); manualN = 1'b1;
    repeat (D + 4) @(posedge clk);

    // R2 recovery
    @(negedge clk); supplyOk = 1'b1;
    edgesUntil(1'b1, n);
    check(n == P + 3, "R2 supply recovery release", n, P + 3);

    // R2 one-cycle dip
    @(negedge clk);
    fork
      begin
        supplyOk = 1'b0;
        @(posedge clk);
        @(negedge clk);
        supplyOk = 1'b1;
      end
      countLows(P + 12, first, lows);
    join
    check(first == 3, "R2 dip assert latency", first, 3);
    check(lows == P + 1, "R2 dip pulse width", lows, P + 1);

    check(compMismatch == 0, "R4 complementary outputs", compMismatch, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule